// File: doc/BRIEF.md
# Sensor Readout Sequence Generator

This block reproduces the digital readout timing of a progressive-scan colour image sensor. It runs on the pixel output clock. From that clock it derives the line drive pulse and the frame drive pulse. It also produces, for every clock, the position of the pixel now on the 8-bit data bus.

Each readout line carries a band of optical-black columns on both sides of the active columns. Each frame carries a band of optical-black lines above and below the active lines. The active columns can be read in descending order, and so can the active lines. A reduced monitoring mode shortens the frame: it keeps two lines, skips the next two, and repeats.

The pixel values are synthesized from the line and column numbers, so a downstream consumer or a testbench can check the read order directly. Mirror and monitoring controls are taken only at a frame boundary, so a change never breaks up the frame in progress. All sizes are parameters. The defaults describe a 655 x 493 active array with a 780-clock line and a 525-line frame (262 lines in monitoring mode).

Top module: `sro_readout_gen`

## Requirements
- R1: `hd` goes high on the first clock of every line, stays high for HD_HIGH clocks, and repeats every LINE_CLKS clocks.
- R2: A frame lasts FRAME_NORM lines when monitoring is off and FRAME_MON lines when it is on.
- R3: `vd` rises VD_OFS clocks into line 0 and stays high for VD_LINES lines. Both of its edges occur while `hd` is high.
- R4: A readout line places OB_COLS black pixels, then ACT_COLS active pixels, then OB_COLS black pixels, all contiguous. On black pixels `ob_flag` is 1 and `row_idx` and `col_idx` are 0.
- R5: Active pixels carry `col_idx` 1 up to ACT_COLS in ascending order, or ACT_COLS down to 1 when horizontal mirroring is on.
- R6: Readout starts at line V_START of the frame. It places OB_ROWS black lines, then the active lines, then OB_ROWS black lines. No other line has any valid pixel.
- R7: With monitoring off, the active lines carry `row_idx` 1 to ACT_ROWS, or ACT_ROWS down to 1 when vertical mirroring is on. `row_idx` stays constant along a line.
- R8: With monitoring on, rows are kept in pairs with the next pair skipped (1, 2, 5, 6, 9 ...). When vertical mirroring is on, the same skipping is counted down from ACT_ROWS (ACT_ROWS, ACT_ROWS-1, ACT_ROWS-4 ...).
- R9: The mirror and monitoring inputs are latched only when a new frame begins. The first frame after reset is normal and unmirrored, whatever the inputs are.
- R10: On an active pixel, `pix_data` equals row_idx mod 16 times 16 plus col_idx mod 16. On a black pixel it equals OB_LEVEL.
- R11: While `pix_valid` is 0, `pix_data`, `ob_flag`, `row_idx` and `col_idx` are 0. During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mirror_h | input | 1 | Read active columns in descending order |
| mirror_v | input | 1 | Read active rows in descending order |
| monitor_en | input | 1 | Reduced-line monitoring mode |
| hd | output | 1 | Line drive pulse |
| vd | output | 1 | Frame drive pulse |
| pix_valid | output | 1 | A pixel is on the bus this clock |
| ob_flag | output | 1 | The current pixel is optical black |
| row_idx | output | $clog2(ACT_ROWS+1) | Active row number, 0 for black |
| col_idx | output | $clog2(ACT_COLS+1) | Active column number, 0 for black |
| pix_data | output | 8 | Synthesized pixel value |

## Verification
The assertions assume that the parameters are consistent. The column window must fit inside a line, and the line window must fit inside the shorter of the two frame lengths. VD_OFS must be smaller than HD_HIGH, and HD_HIGH + 1 must be smaller than LINE_CLKS. The control inputs are treated as free-running: they may change on any clock, so nothing is assumed about when they toggle. The bench uses a shrunken but consistent parameter set. It changes the controls at frame starts, in mid-frame and while reset is held, so that the boundary latching is exercised under each of these conditions.

// File: rtl/sro_pkg.sv
package sro_pkg;

    typedef struct packed {
        logic mir_h;
        logic mir_v;
        logic mon;
    } sro_cfg_t;

    // rows kept by the pair-keep/pair-skip pattern out of a given row count
    function automatic int kept_rows(input int rows);
        return (rows / 4) * 2 + (((rows % 4) > 1) ? 2 : (rows % 4));
    endfunction

endpackage

// File: rtl/sro_timing.sv
module sro_timing
    import sro_pkg::*;
#(
    parameter int LINE_CLKS  = 780,
    parameter int HD_HIGH    = 79,
    parameter int FRAME_NORM = 525,
    parameter int FRAME_MON  = 262,
    parameter int VD_LINES   = 3,
    parameter int VD_OFS     = 40,
    parameter int HW         = $clog2(LINE_CLKS),
    parameter int VW         = $clog2(FRAME_NORM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sro_cfg_t      cfg_i,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output sro_cfg_t      cfg_o,
    output logic          hd_o,
    output logic          vd_o
);

    localparam logic [HW-1:0] H_LAST      = HW'(LINE_CLKS - 1);
    localparam logic [VW-1:0] V_LAST_NORM = VW'(FRAME_NORM - 1);
    localparam logic [VW-1:0] V_LAST_MON  = VW'(FRAME_MON - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        sro_cfg_t      cfg;
        logic          hd;
        logic          vd;
    } tim_t;

    tim_t          s_d, s_q;
    logic [VW-1:0] last_line;

    always_comb begin
        s_d       = s_q;
        last_line = s_q.cfg.mon ? V_LAST_MON : V_LAST_NORM;
        if (s_q.h == H_LAST) begin
            s_d.h = '0;
            if (s_q.v == last_line) begin
                s_d.v   = '0;
                s_d.cfg = cfg_i;
            end else begin
                s_d.v = s_q.v + 1'b1;
            end
        end else begin
            s_d.h = s_q.h + 1'b1;
        end
        s_d.hd = (int'(s_q.h) < HD_HIGH);
        s_d.vd = ((int'(s_q.v) < VD_LINES) && !((s_q.v == '0) && (int'(s_q.h) < VD_OFS)))
              || ((int'(s_q.v) == VD_LINES) && (int'(s_q.h) < VD_OFS));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign h_o   = s_q.h;
    assign v_o   = s_q.v;
    assign cfg_o = s_q.cfg;
    assign hd_o  = s_q.hd;
    assign vd_o  = s_q.vd;

    a_r1_hd_rise_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.hd) |-> (s_q.h == HW'(1)));

    a_r1_hd_fall_after_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.hd) |-> (s_q.h == HW'(HD_HIGH + 1)));

    a_r2_frame_wrap_length: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.v == '0) && ($past(s_q.v) != '0)) |-> ($past(s_q.v) == $past(last_line)));

    a_r3_vd_edge_inside_hd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.vd) |-> s_q.hd);

    a_r9_cfg_only_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.cfg) |-> ((s_q.h == '0) && (s_q.v == '0)));

endmodule

// File: rtl/sro_row_map.sv
module sro_row_map #(
    parameter int ACT_ROWS = 493,
    parameter int OB_ROWS  = 3,
    parameter int V_START  = 6,
    parameter int VW       = 10,
    parameter int RW       = $clog2(ACT_ROWS + 1)
) (
    input  logic [VW-1:0] v_i,
    input  logic          mon_i,
    input  logic          mir_v_i,
    output logic          on_o,
    output logic          ob_o,
    output logic [RW-1:0] row_o
);

    localparam int MON_ROWS = sro_pkg::kept_rows(ACT_ROWS);

    int k_v, j_v, n_v, act_v;

    always_comb begin
        on_o  = 1'b0;
        ob_o  = 1'b0;
        row_o = '0;
        act_v = mon_i ? MON_ROWS : ACT_ROWS;
        k_v   = int'(v_i) - V_START;
        j_v   = k_v - OB_ROWS;
        n_v   = mon_i ? (((j_v >> 1) << 2) + (j_v & 1)) : j_v;
        if (k_v >= 0) begin
            if (k_v < OB_ROWS) begin
                on_o = 1'b1;
                ob_o = 1'b1;
            end else if (j_v < act_v) begin
                on_o  = 1'b1;
                row_o = RW'(mir_v_i ? (ACT_ROWS - n_v) : (n_v + 1));
            end else if (j_v < act_v + OB_ROWS) begin
                on_o = 1'b1;
                ob_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sro_col_map.sv
module sro_col_map #(
    parameter int ACT_COLS = 655,
    parameter int OB_COLS  = 24,
    parameter int H_START  = 8,
    parameter int HW       = 10,
    parameter int CW       = $clog2(ACT_COLS + 1)
) (
    input  logic [HW-1:0] h_i,
    input  logic          mir_h_i,
    output logic          on_o,
    output logic          ob_o,
    output logic [CW-1:0] col_o
);

    localparam int TOT_COLS = 2 * OB_COLS + ACT_COLS;

    int c_v, m_v;

    always_comb begin
        on_o  = 1'b0;
        ob_o  = 1'b0;
        col_o = '0;
        c_v   = int'(h_i) - H_START;
        m_v   = c_v - OB_COLS;
        if (c_v >= 0 && c_v < TOT_COLS) begin
            on_o = 1'b1;
            if (m_v < 0 || m_v >= ACT_COLS) ob_o = 1'b1;
            else col_o = CW'(mir_h_i ? (ACT_COLS - m_v) : (m_v + 1));
        end
    end

endmodule

// File: rtl/sro_readout_gen.sv
module sro_readout_gen
    import sro_pkg::*;
#(
    parameter int ACT_COLS   = 655,
    parameter int ACT_ROWS   = 493,
    parameter int OB_COLS    = 24,
    parameter int OB_ROWS    = 3,
    parameter int LINE_CLKS  = 780,
    parameter int HD_HIGH    = 79,
    parameter int H_START    = 8,
    parameter int FRAME_NORM = 525,
    parameter int FRAME_MON  = 262,
    parameter int V_START    = 6,
    parameter int VD_LINES   = 3,
    parameter int VD_OFS     = 40,
    parameter int OB_LEVEL   = 16,
    parameter int RW         = $clog2(ACT_ROWS + 1),
    parameter int CW         = $clog2(ACT_COLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mirror_h,
    input  logic          mirror_v,
    input  logic          monitor_en,
    output logic          hd,
    output logic          vd,
    output logic          pix_valid,
    output logic          ob_flag,
    output logic [RW-1:0] row_idx,
    output logic [CW-1:0] col_idx,
    output logic [7:0]    pix_data
);

    localparam int HW = $clog2(LINE_CLKS);
    localparam int VW = $clog2(FRAME_NORM);

    typedef struct packed {
        logic          valid;
        logic          ob;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic [7:0]    data;
    } out_t;

    sro_cfg_t      cfg_in, cfg_cur;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          line_on, line_ob, px_on, px_ob;
    logic [RW-1:0] row_m;
    logic [CW-1:0] col_m;
    out_t          o_d, o_q;

    assign cfg_in = '{mir_h: mirror_h, mir_v: mirror_v, mon: monitor_en};

    sro_timing #(
        .LINE_CLKS(LINE_CLKS), .HD_HIGH(HD_HIGH), .FRAME_NORM(FRAME_NORM),
        .FRAME_MON(FRAME_MON), .VD_LINES(VD_LINES), .VD_OFS(VD_OFS),
        .HW(HW), .VW(VW)
    ) i_timing (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_in),
        .h_o(h_cnt), .v_o(v_cnt), .cfg_o(cfg_cur), .hd_o(hd), .vd_o(vd)
    );

    sro_row_map #(
        .ACT_ROWS(ACT_ROWS), .OB_ROWS(OB_ROWS), .V_START(V_START), .VW(VW), .RW(RW)
    ) i_row_map (
        .v_i(v_cnt), .mon_i(cfg_cur.mon), .mir_v_i(cfg_cur.mir_v),
        .on_o(line_on), .ob_o(line_ob), .row_o(row_m)
    );

    sro_col_map #(
        .ACT_COLS(ACT_COLS), .OB_COLS(OB_COLS), .H_START(H_START), .HW(HW), .CW(CW)
    ) i_col_map (
        .h_i(h_cnt), .mir_h_i(cfg_cur.mir_h),
        .on_o(px_on), .ob_o(px_ob), .col_o(col_m)
    );

    always_comb begin
        o_d       = '0;
        o_d.valid = line_on && px_on;
        if (o_d.valid) begin
            o_d.ob = line_ob || px_ob;
            if (o_d.ob) begin
                o_d.data = 8'(OB_LEVEL);
            end else begin
                o_d.row  = row_m;
                o_d.col  = col_m;
                o_d.data = 8'((int'(row_m) % 16) * 16 + (int'(col_m) % 16));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pix_valid = o_q.valid;
    assign ob_flag   = o_q.ob;
    assign row_idx   = o_q.row;
    assign col_idx   = o_q.col;
    assign pix_data  = o_q.data;

    a_r4_ob_indices_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ob_flag) |-> ((row_idx == '0) && (col_idx == '0)));

    a_r10_ob_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ob_flag) |-> (pix_data == 8'(OB_LEVEL)));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> ((pix_data == '0) && !ob_flag && (row_idx == '0) && (col_idx == '0)));

    a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !ob_flag && $past(pix_valid && !ob_flag)) |->
        (col_idx == (cfg_cur.mir_h ? CW'($past(col_idx) - 1'b1) : CW'($past(col_idx) + 1'b1))));

    a_r7_row_hold_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !ob_flag && $past(pix_valid && !ob_flag)) |-> $stable(row_idx));

endmodule

// File: tb/test_sro_readout_gen.sv
module test_sro_readout_gen;

    localparam int CLK_PERIOD = 10;
    localparam int ACT_COLS = 6, ACT_ROWS = 9, OB_COLS = 2, OB_ROWS = 1;
    localparam int LINE_CLKS = 20, HD_HIGH = 4, H_START = 3;
    localparam int FRAME_NORM = 16, FRAME_MON = 10, V_START = 2;
    localparam int VD_LINES = 2, VD_OFS = 2, OB_LEVEL = 16;
    localparam int RW = 4, CW = 3;
    localparam int TOT_COLS = 2 * OB_COLS + ACT_COLS;

    typedef struct packed {
        logic       mh;
        logic       mv;
        logic       mon;
        logic [7:0] first_row;
        logic [7:0] first_col;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{mh: 1'b0, mv: 1'b0, mon: 1'b0, first_row: 8'd1, first_col: 8'd1},
        '{mh: 1'b1, mv: 1'b0, mon: 1'b0, first_row: 8'd1, first_col: 8'd6},
        '{mh: 1'b0, mv: 1'b1, mon: 1'b0, first_row: 8'd9, first_col: 8'd1},
        '{mh: 1'b0, mv: 1'b0, mon: 1'b1, first_row: 8'd1, first_col: 8'd1},
        '{mh: 1'b0, mv: 1'b1, mon: 1'b1, first_row: 8'd9, first_col: 8'd1},
        '{mh: 1'b1, mv: 1'b1, mon: 1'b1, first_row: 8'd9, first_col: 8'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mirror_h = 1'b0, mirror_v = 1'b0, monitor_en = 1'b0;
    logic hd, vd, pix_valid, ob_flag;
    logic [RW-1:0] row_idx;
    logic [CW-1:0] col_idx;
    logic [7:0] pix_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sro_readout_gen #(
        .ACT_COLS(ACT_COLS), .ACT_ROWS(ACT_ROWS), .OB_COLS(OB_COLS), .OB_ROWS(OB_ROWS),
        .LINE_CLKS(LINE_CLKS), .HD_HIGH(HD_HIGH), .H_START(H_START),
        .FRAME_NORM(FRAME_NORM), .FRAME_MON(FRAME_MON), .V_START(V_START),
        .VD_LINES(VD_LINES), .VD_OFS(VD_OFS), .OB_LEVEL(OB_LEVEL)
    ) i_sro_readout_gen (
        .clk(clk), .rst_n(rst_n), .mirror_h(mirror_h), .mirror_v(mirror_v),
        .monitor_en(monitor_en), .hd(hd), .vd(vd), .pix_valid(pix_valid),
        .ob_flag(ob_flag), .row_idx(row_idx), .col_idx(col_idx), .pix_data(pix_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_vd_rise();
        logic p;
        p = vd;
        forever begin
            @(negedge clk);
            if (vd && !p) break;
            p = vd;
        end
    endtask

    // starts at a sample where vd has just risen; returns at the next such sample
    task automatic capture(input logic mh, input logic mv, input logic mon,
                           input int frow, input int fcol);
        int exp_rows[16];
        int got_rows[16];
        int n_exp = 0, n_got = 0, cycles = 0, hd_cnt = 0, vd_cnt = 0;
        int ob_cnt = 0, act_cnt = 0, col_k = 0, col_err = 0, row_err = 0, vdhd_err = 0;
        int cur_row = 0, lines, d_act = -1, d_exp = 0;
        logic p_hd, p_vd;
        bit first = 1'b1;
        for (int n = 0; n < ACT_ROWS; n++) begin
            if (!mon || (n % 4) < 2) begin
                exp_rows[n_exp] = mv ? (ACT_ROWS - n) : (n + 1);
                n_exp++;
            end
        end
        lines = mon ? FRAME_MON : FRAME_NORM;
        p_hd = hd;
        p_vd = 1'b0;
        do begin
            if (hd) hd_cnt++;
            if (vd) vd_cnt++;
            if (vd != p_vd && !hd) vdhd_err++;
            if (hd && !p_hd) col_k = 0;
            if (pix_valid && ob_flag) ob_cnt++;
            if (pix_valid && !ob_flag) begin
                act_cnt++;
                if (col_k == 0) begin
                    cur_row = int'(row_idx);
                    if (n_got < 16) got_rows[n_got] = cur_row;
                    n_got++;
                end else if (int'(row_idx) != cur_row) begin
                    row_err++;
                end
                if (int'(col_idx) != (mh ? (ACT_COLS - col_k) : (col_k + 1))) col_err++;
                if (first) begin
                    d_act = int'(pix_data);
                    d_exp = (frow % 16) * 16 + (fcol % 16);
                    chk(int'(row_idx) == frow, "R7/R8 first row", int'(row_idx), frow);
                    chk(int'(col_idx) == fcol, "R5 first column", int'(col_idx), fcol);
                    first = 1'b0;
                end
                col_k++;
            end
            p_hd = hd;
            p_vd = vd;
            @(negedge clk);
            cycles++;
        end while (!(vd && !p_vd));
        chk(cycles == lines * LINE_CLKS, "R2 frame length", cycles, lines * LINE_CLKS);
        chk(hd_cnt == lines * HD_HIGH, "R1 hd high clocks", hd_cnt, lines * HD_HIGH);
        chk(vd_cnt == VD_LINES * LINE_CLKS, "R3 vd width", vd_cnt, VD_LINES * LINE_CLKS);
        chk(vdhd_err == 0, "R3 vd edge outside hd", vdhd_err, 0);
        chk(n_got == n_exp, "R6 active line count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got && i < 16; i++)
            chk(got_rows[i] == exp_rows[i], mon ? "R8 monitor row order" : "R7 row order",
                got_rows[i], exp_rows[i]);
        chk(row_err == 0, "R7 row changes inside line", row_err, 0);
        chk(col_err == 0, "R5 column order", col_err, 0);
        chk(act_cnt == n_exp * ACT_COLS, "R4 active pixel count", act_cnt, n_exp * ACT_COLS);
        chk(ob_cnt == 2 * OB_ROWS * TOT_COLS + n_exp * 2 * OB_COLS, "R4/R6 black pixel count",
            ob_cnt, 2 * OB_ROWS * TOT_COLS + n_exp * 2 * OB_COLS);
        chk(d_act == d_exp, "R10 pixel value", d_act, d_exp);
    endtask

    task automatic set_cfg(input logic mh, input logic mv, input logic mon);
        mirror_h   = mh;
        mirror_v   = mv;
        monitor_en = mon;
    endtask

    initial begin
        // R9: inputs request everything before reset is released
        set_cfg(1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!hd && !vd && !pix_valid && !ob_flag, "R11 reset outputs", int'({hd, vd, pix_valid, ob_flag}), 0);
        chk(row_idx == '0 && col_idx == '0 && pix_data == '0, "R11 reset indices",
            int'(pix_data), 0);
        rst_n = 1'b1;
        wait_vd_rise();
        capture(1'b0, 1'b0, 1'b0, 1, 1);          // R9 first frame normal
        capture(1'b1, 1'b1, 1'b1, 9, 6);          // R9 latched at next frame
        set_cfg(1'b0, 1'b0, 1'b0);
        wait_vd_rise();
        // R9: mid-frame change must not alter the frame in progress
        fork
            capture(1'b0, 1'b0, 1'b0, 1, 1);
            begin
                repeat (100) @(negedge clk);
                set_cfg(1'b1, 1'b1, 1'b1);
            end
        join
        capture(1'b1, 1'b1, 1'b1, 9, 6);
        for (int i = 0; i < 6; i++) begin
            set_cfg(VECS[i].mh, VECS[i].mv, VECS[i].mon);
            wait_vd_rise();
            capture(VECS[i].mh, VECS[i].mv, VECS[i].mon,
                    int'(VECS[i].first_row), int'(VECS[i].first_col));
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule